// File: doc/BRIEF.md
# Parallel Bus Initiator Sequencer

This block is the master side of a synchronous bus that shares 32 lines between address and data and uses active-low control strobes. A user starts a transfer with a single-cycle pulse that carries the command, a 64-bit start address, a beat count and a set of byte enables. The sequencer then requests the bus and waits for a grant while the bus is idle. It drives one address phase, or two when the upper address half is non-zero, and then runs data phases until the count is used up. Write data is fetched per beat through a beat index. Read data is handed back with a one-cycle valid strobe.

The target may stall any data phase, or it may end the tenure early with its stop strobe. The sequencer classifies each early end as a retry (no beat done in that tenure) or a disconnect (at least one beat done). It releases the bus, requests it again and continues from the first beat that has not completed. The transfer finishes with a done pulse.

Top module: `pbus_init_seq`

## Requirements
- R1: While reset is held and after it, req_no, frame_no and irdy_no are high, ad_oe_o is low, busy_o is low and no retry, disconnect, done or read-valid pulse is present.
- R2: After an accepted start, req_no stays low until an address phase begins. An address phase begins only in the clock after one in which gnt_ni was low and both frame_ni and irdy_ni were high.
- R3: When the current address has a zero upper half, one address phase is driven. In it frame_no is low, ad_oe_o is high, ad_o is the low address half and cbe_no is the command. The command is a 4-bit code whose bit 0 set means write and clear means read.
- R4: When the upper half is non-zero, two address phases are driven. The first carries the low half with cbe_no = 4'hD. The second carries the high half with cbe_no = the command.
- R5: In every data phase irdy_no is low and cbe_no is the inverse of the byte enables. A write drives ad_o with wr_data_i for the beat index on wr_idx_o, with ad_oe_o high. A read leaves ad_oe_o low. A beat completes only on an edge where trdy_ni is low. Otherwise the phase repeats with the same beat index.
- R6: frame_no is high during the final data phase. irdy_no goes high in the clock after the last beat completes. In that same clock done_o pulses for one cycle and busy_o is low.
- R7: For reads, rd_valid_o pulses one clock after each completing edge, with rd_data_o equal to ad_i at that edge. No pulse appears on other clocks.
- R8: stop_ni low in a data phase with no beat completed in the current tenure (none at that edge) gives a one-cycle retry_o pulse. The sequencer then requests the bus again and repeats the address phase with the same address and the same remaining count.
- R9: stop_ni low after one or more beats of the tenure (a beat with trdy_ni low at the same edge counts) gives a one-cycle disc_o pulse. The sequencer resumes at the start address plus 4 times the completed beats, with the remaining count. If that beat was the last one, done_o pulses instead.
- R10: On a stop while frame_no is low, the next clock has frame_no high and irdy_no low, and the clock after has irdy_no high. On a stop during the final phase, irdy_no goes high in the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, accepted when idle with a non-zero count |
| cmd_i | input | 4 | Command code, bit 0 = write |
| addr_i | input | 64 | Byte start address |
| beats_i | input | BEAT_W | Number of data beats |
| be_i | input | 4 | Byte enables, active high, held for the whole transfer |
| wr_data_i | input | 32 | Write data for the beat shown on wr_idx_o |
| wr_idx_o | output | BEAT_W | Beats completed since start |
| rd_data_o | output | 32 | Captured read data |
| rd_valid_o | output | 1 | Read data strobe |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | Transfer complete pulse |
| retry_o | output | 1 | Retry termination pulse |
| disc_o | output | 1 | Disconnect termination pulse |
| req_no | output | 1 | Bus request, active low |
| gnt_ni | input | 1 | Bus grant, active low |
| frame_ni | input | 1 | Observed bus frame strobe |
| irdy_ni | input | 1 | Observed bus initiator-ready strobe |
| frame_no | output | 1 | Driven frame strobe |
| irdy_no | output | 1 | Driven initiator-ready strobe |
| trdy_ni | input | 1 | Target ready, active low |
| stop_ni | input | 1 | Target stop, active low |
| ad_o | output | 32 | Address/data out |
| ad_oe_o | output | 1 | Address/data output enable |
| ad_i | input | 32 | Address/data in |
| cbe_no | output | 4 | Command / byte enables, active low |

## Verification
A corrupted beat counter or address register shows first when a transfer resumes: the repeated address phase, one clock after the new grant, carries the wrong address, or a transfer ends with frame_no released one beat early or late. A misclassified termination shows as a wrong pulse on retry_o or disc_o in the clock after the stop edge. A stuck state shows as irdy_no or frame_no failing to release in the next clock. Directed transfers cross the 32-bit address boundary so that a resume switches from one to two address phases, and they stop on the final beat both with and without a completing beat.

// File: rtl/pbus_pkg.sv
package pbus_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_ADR_LO,
    ST_ADR_HI,
    ST_DATA,
    ST_STOP_REL
  } pbus_state_e;

  localparam logic [3:0] CMD_DUAL_ADDR = 4'hD;
  localparam int unsigned BUS_W = 32;
  localparam int unsigned ADDR_W = 2 * BUS_W;
  localparam int unsigned BE_W = BUS_W / 8;
endpackage

// File: rtl/pbus_xfer_track.sv
module pbus_xfer_track
  import pbus_pkg::*;
#(
  parameter int unsigned BEAT_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BEAT_W-1:0] beats_i,
  input  logic              beat_done_i,
  input  logic              tenure_clr_i,
  output logic [ADDR_W-1:0] cur_addr_o,
  output logic [BEAT_W-1:0] idx_o,
  output logic              last_o,
  output logic              tenure_beat_o
);
  localparam logic [ADDR_W-1:0] STRIDE = ADDR_W'(BE_W);

  logic [BEAT_W-1:0] remain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_addr_o    <= '0;
      remain_q      <= '0;
      idx_o         <= '0;
      tenure_beat_o <= 1'b0;
    end else if (load_i) begin
      cur_addr_o    <= addr_i;
      remain_q      <= beats_i;
      idx_o         <= '0;
      tenure_beat_o <= 1'b0;
    end else if (beat_done_i) begin
      cur_addr_o    <= cur_addr_o + STRIDE;
      remain_q      <= remain_q - 1'b1;
      idx_o         <= idx_o + 1'b1;
      tenure_beat_o <= 1'b1;
    end else if (tenure_clr_i) begin
      tenure_beat_o <= 1'b0;
    end
  end

  assign last_o = (remain_q == BEAT_W'(1));

  // R9: a beat never completes with nothing left to move
  a_r9_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_done_i |-> (remain_q != '0));
endmodule

// File: rtl/pbus_rd_capture.sv
module pbus_rd_capture
  import pbus_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             beat_done_i,
  input  logic             is_read_i,
  input  logic [BUS_W-1:0] ad_i,
  output logic [BUS_W-1:0] rd_data_o,
  output logic             rd_valid_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_data_o  <= '0;
      rd_valid_o <= 1'b0;
    end else begin
      rd_valid_o <= beat_done_i && is_read_i;
      if (beat_done_i && is_read_i) rd_data_o <= ad_i;
    end
  end

  // R7: captured data only moves on a completing read beat
  a_r7_data_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(beat_done_i && is_read_i) |=> $stable(rd_data_o));
endmodule

// File: rtl/pbus_init_seq.sv
module pbus_init_seq
  import pbus_pkg::*;
#(
  parameter int unsigned BEAT_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [3:0]        cmd_i,
  input  logic [63:0]       addr_i,
  input  logic [BEAT_W-1:0] beats_i,
  input  logic [3:0]        be_i,
  input  logic [31:0]       wr_data_i,
  output logic [BEAT_W-1:0] wr_idx_o,
  output logic [31:0]       rd_data_o,
  output logic              rd_valid_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              retry_o,
  output logic              disc_o,
  output logic              req_no,
  input  logic              gnt_ni,
  input  logic              frame_ni,
  input  logic              irdy_ni,
  output logic              frame_no,
  output logic              irdy_no,
  input  logic              trdy_ni,
  input  logic              stop_ni,
  output logic [31:0]       ad_o,
  output logic              ad_oe_o,
  input  logic [31:0]       ad_i,
  output logic [3:0]        cbe_no
);
  pbus_state_e state_q, state_d;
  logic [3:0]        cmd_q;
  logic [BE_W-1:0]   be_q;
  logic [ADDR_W-1:0] cur_addr;
  logic              last, tenure_beat;
  logic              load, beat_done, stop_seen, last_done, dual, is_wr;

  assign is_wr     = cmd_q[0];
  assign dual      = (cur_addr[ADDR_W-1:BUS_W] != '0);
  assign load      = (state_q == ST_IDLE) && start_i && (beats_i != '0);
  assign beat_done = (state_q == ST_DATA) && !trdy_ni;
  assign stop_seen = (state_q == ST_DATA) && !stop_ni;
  assign last_done = beat_done && last;

  pbus_xfer_track #(.BEAT_W(BEAT_W)) u_track (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .load_i       (load),
    .addr_i       (addr_i),
    .beats_i      (beats_i),
    .beat_done_i  (beat_done),
    .tenure_clr_i (state_q == ST_ADR_LO),
    .cur_addr_o   (cur_addr),
    .idx_o        (wr_idx_o),
    .last_o       (last),
    .tenure_beat_o(tenure_beat)
  );

  pbus_rd_capture u_rd (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .beat_done_i(beat_done),
    .is_read_i  (!is_wr),
    .ad_i       (ad_i),
    .rd_data_o  (rd_data_o),
    .rd_valid_o (rd_valid_o)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:     if (load) state_d = ST_REQ;
      ST_REQ:      if (!gnt_ni && frame_ni && irdy_ni) state_d = ST_ADR_LO;
      ST_ADR_LO:   state_d = dual ? ST_ADR_HI : ST_DATA;
      ST_ADR_HI:   state_d = ST_DATA;
      ST_DATA: begin
        if (last_done)      state_d = ST_IDLE;
        else if (stop_seen) state_d = last ? ST_REQ : ST_STOP_REL;
      end
      ST_STOP_REL: state_d = ST_REQ;
      default:     state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cmd_q   <= '0;
      be_q    <= '0;
      done_o  <= 1'b0;
      retry_o <= 1'b0;
      disc_o  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (load) begin
        cmd_q <= cmd_i;
        be_q  <= be_i;
      end
      done_o  <= last_done;
      retry_o <= stop_seen && !last_done && !beat_done && !tenure_beat;
      disc_o  <= stop_seen && !last_done && (beat_done || tenure_beat);
    end
  end

  assign busy_o   = (state_q != ST_IDLE);
  assign req_no   = (state_q != ST_REQ);
  assign frame_no = !((state_q == ST_ADR_LO) || (state_q == ST_ADR_HI) ||
                      ((state_q == ST_DATA) && !last));
  assign irdy_no  = !((state_q == ST_DATA) || (state_q == ST_STOP_REL));
  assign ad_oe_o  = (state_q == ST_ADR_LO) || (state_q == ST_ADR_HI) ||
                    ((state_q == ST_DATA) && is_wr);

  always_comb begin
    ad_o   = '0;
    cbe_no = '1;
    unique case (state_q)
      ST_ADR_LO: begin
        ad_o   = cur_addr[BUS_W-1:0];
        cbe_no = dual ? CMD_DUAL_ADDR : cmd_q;
      end
      ST_ADR_HI: begin
        ad_o   = cur_addr[ADDR_W-1:BUS_W];
        cbe_no = cmd_q;
      end
      ST_DATA: begin
        ad_o   = is_wr ? wr_data_i : '0;
        cbe_no = ~be_q;
      end
      default: ;
    endcase
  end

  // R2: address phase only after a grant seen on an idle bus
  a_r2_addr_after_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(frame_no) |-> $past(!gnt_ni && frame_ni && irdy_ni));
  // R5: a stalled data phase repeats with the same beat index
  a_r5_wait_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irdy_no && !frame_no && trdy_ni && stop_ni) |=> (!irdy_no && $stable(wr_idx_o)));
  // R6: initiator ready released after the final beat
  a_r6_irdy_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irdy_no && frame_no && !trdy_ni) |=> irdy_no);
  // R10: a stop with frame still asserted drops frame next clock
  a_r10_stop_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irdy_no && !frame_no && !stop_ni) |=> (frame_no && !irdy_no));
  // R8/R9: at most one ending pulse per clock
  a_r8_one_outcome: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({retry_o, disc_o, done_o}));
  // R7: read strobe follows a completing beat
  a_r7_valid_after_beat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> $past(!irdy_no && !trdy_ni));
endmodule

// File: tb/pbus_init_seq_tb.sv
`timescale 1ns/1ps
module pbus_init_seq_tb;
  localparam int BEAT_W = 8;

  typedef enum int {T_IDLE, T_WADDR, T_HI, T_DATA, T_REL, T_END} tstate_e;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic [3:0] cmd_i = '0;
  logic [63:0] addr_i = '0;
  logic [BEAT_W-1:0] beats_i = '0;
  logic [3:0] be_i = '0;
  logic [31:0] wr_data_i;
  logic [BEAT_W-1:0] wr_idx_o;
  logic [31:0] rd_data_o;
  logic rd_valid_o, busy_o, done_o, retry_o, disc_o, req_no;
  logic gnt_ni = 1'b1;
  logic frame_ni, irdy_ni, frame_no, irdy_no;
  logic trdy_ni = 1'b1;
  logic stop_ni = 1'b1;
  logic [31:0] ad_o, ad_i;
  logic ad_oe_o;
  logic [3:0] cbe_no;
  logic other_busy = 1'b0;
  logic [7:0] tag = '0;

  always #2 clk = ~clk;

  function automatic logic [31:0] wd(input logic [7:0] t, input logic [BEAT_W-1:0] i);
    return {t, 8'(i), t ^ 8'h3C, 8'(i) ^ 8'hC3};
  endfunction

  function automatic logic [31:0] rdfun(input logic [63:0] a);
    return (a[31:0] * 32'h9E3779B1) ^ a[63:32];
  endfunction

  assign wr_data_i = wd(tag, wr_idx_o);
  assign frame_ni  = frame_no & ~other_busy;
  assign irdy_ni   = irdy_no & ~other_busy;

  pbus_init_seq #(.BEAT_W(BEAT_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .cmd_i(cmd_i), .addr_i(addr_i),
    .beats_i(beats_i), .be_i(be_i), .wr_data_i(wr_data_i), .wr_idx_o(wr_idx_o),
    .rd_data_o(rd_data_o), .rd_valid_o(rd_valid_o), .busy_o(busy_o), .done_o(done_o),
    .retry_o(retry_o), .disc_o(disc_o), .req_no(req_no), .gnt_ni(gnt_ni),
    .frame_ni(frame_ni), .irdy_ni(irdy_ni), .frame_no(frame_no), .irdy_no(irdy_no),
    .trdy_ni(trdy_ni), .stop_ni(stop_ni), .ad_o(ad_o), .ad_oe_o(ad_oe_o), .ad_i(ad_i),
    .cbe_no(cbe_no)
  );

  int n_chk = 0, n_err = 0, cycles = 0;
  tstate_e ts = T_IDLE;
  logic [63:0] exp_addr;
  int exp_rem, exp_idx, tenure_beats, stops_left, disc_after;
  bit disc_tr, force_retry, rand_stop, resume, cur_rd;
  bit exp_rdv, exp_done, exp_retry, exp_disc;
  logic [31:0] exp_rdd;
  bit prev_gnt_ok, prev_idle;
  logic [3:0] cur_cmd, cur_be;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    bit tr, st, was_last;
    // pulses expected from the previous clock
    chk(retry_o == exp_retry, "R8 retry pulse", 64'(retry_o), 64'(exp_retry));
    chk(disc_o == exp_disc, "R9 disc pulse", 64'(disc_o), 64'(exp_disc));
    chk(done_o == exp_done, "R6 done pulse", 64'(done_o), 64'(exp_done));
    chk(rd_valid_o == exp_rdv, "R7 read valid", 64'(rd_valid_o), 64'(exp_rdv));
    if (exp_rdv) chk(rd_data_o == exp_rdd, "R7 read data", 64'(rd_data_o), 64'(exp_rdd));
    exp_retry = 0; exp_disc = 0; exp_done = 0; exp_rdv = 0;
    trdy_ni = 1'b1; stop_ni = 1'b1;
    case (ts)
      T_WADDR: begin
        if (!frame_no) begin
          chk(prev_gnt_ok && prev_idle, "R2 grant on idle bus", 64'(prev_gnt_ok), 64'd1);
          chk(ad_oe_o && ad_o == exp_addr[31:0], "R3 low address", 64'(ad_o), exp_addr[31:0]);
          if (exp_addr[63:32] != 0) begin
            chk(cbe_no == 4'hD, "R4 dual code", 64'(cbe_no), 64'hD);
            ts = T_HI;
          end else begin
            chk(cbe_no == cur_cmd, "R3 command", 64'(cbe_no), 64'(cur_cmd));
            ts = T_DATA;
          end
          tenure_beats = 0;
          gnt_ni = 1'b1; other_busy = 1'b0;
        end else if (!req_no) begin
          gnt_ni = ($urandom % 3 == 0);
          other_busy = ($urandom % 4 == 0);
        end else begin
          gnt_ni = 1'b1; other_busy = 1'b0;
        end
      end
      T_HI: begin
        chk(!frame_no && ad_o == exp_addr[63:32], "R4 high address", 64'(ad_o), exp_addr[63:32]);
        chk(cbe_no == cur_cmd, "R4 command", 64'(cbe_no), 64'(cur_cmd));
        ts = T_DATA;
      end
      T_DATA: begin
        chk(!irdy_no, "R5 irdy low", 64'(irdy_no), 64'd0);
        chk(frame_no == (exp_rem == 1), "R6 frame on last", 64'(frame_no), 64'(exp_rem == 1));
        chk(cbe_no == ~cur_be, "R5 byte enables", 64'(cbe_no), 64'(~cur_be));
        chk(wr_idx_o == exp_idx, "R5 beat index", 64'(wr_idx_o), 64'(exp_idx));
        if (cur_rd) chk(!ad_oe_o, "R5 read no drive", 64'(ad_oe_o), 64'd0);
        else chk(ad_oe_o && ad_o == wd(tag, BEAT_W'(exp_idx)), "R5 write data", 64'(ad_o), 64'(wd(tag, BEAT_W'(exp_idx))));
        tr = ($urandom % 100 < 65);
        st = 0;
        if (force_retry) begin
          tr = 0; st = 1; force_retry = 0;
        end else if (disc_after > 0 && tenure_beats == disc_after) begin
          tr = disc_tr; st = 1; disc_after = -1;
        end else if (disc_after < 0 && rand_stop && stops_left > 0 && $urandom % 8 == 0) begin
          st = 1; stops_left--;
        end
        trdy_ni = !tr; stop_ni = !st;
        was_last = frame_no;
        if (tr) begin
          if (cur_rd) begin
            ad_i = rdfun(exp_addr);
            exp_rdv = 1; exp_rdd = ad_i;
          end
          exp_addr += 4; exp_rem--; exp_idx++;
        end
        if (tr && exp_rem == 0) begin
          exp_done = 1; resume = 0; ts = T_END;
        end else if (st) begin
          if (tenure_beats == 0 && !tr) exp_retry = 1; else exp_disc = 1;
          resume = 1;
          ts = was_last ? T_END : T_REL;
        end
        if (tr) tenure_beats++;
      end
      T_REL: begin
        chk(frame_no && !irdy_no, "R10 frame released first", {frame_no, irdy_no}, 64'b10);
        ts = T_WADDR;
      end
      T_END: begin
        chk(frame_no && irdy_no, "R6/R10 irdy released", {frame_no, irdy_no}, 64'b11);
        if (!resume) chk(!busy_o, "R6 busy low", 64'(busy_o), 64'd0);
        ts = resume ? T_WADDR : T_IDLE;
      end
      default: ;
    endcase
    prev_gnt_ok = !gnt_ni;
    prev_idle = !other_busy;
  endtask

  task automatic xfer(input logic [3:0] c, input logic [63:0] a, input int n, input logic [3:0] be,
                      input bit fr, input int da, input bit dtr, input bit rs);
    int lim;
    @(negedge clk);
    step();
    tag = 8'($urandom);
    cmd_i = c; addr_i = a; beats_i = BEAT_W'(n); be_i = be; start_i = 1'b1;
    cur_cmd = c; cur_be = be; cur_rd = !c[0];
    exp_addr = a; exp_rem = n; exp_idx = 0;
    force_retry = fr; disc_after = da; disc_tr = dtr; rand_stop = rs; stops_left = 3;
    ts = T_WADDR;
    @(negedge clk);
    start_i = 1'b0;
    step();
    chk(busy_o, "R2 busy after start", 64'(busy_o), 64'd1);
    chk(!req_no, "R2 request after start", 64'(req_no), 64'd0);
    lim = 0;
    while (ts != T_IDLE && lim < 2000 && cycles < 150000) begin
      @(negedge clk);
      step();
      lim++;
    end
    if (ts != T_IDLE) chk(0, "watchdog", 64'(ts), 64'(T_IDLE));
    ts = T_IDLE;
  endtask

  always @(posedge clk) cycles++;

  initial begin
    void'($urandom(32'd4242));
    ad_i = '0;
    exp_retry = 0; exp_disc = 0; exp_done = 0; exp_rdv = 0; exp_rdd = '0;
    prev_gnt_ok = 0; prev_idle = 1;
    repeat (3) @(negedge clk);
    chk(req_no && frame_no && irdy_no && !ad_oe_o && !busy_o, "R1 reset idle", {req_no, frame_no, irdy_no, ad_oe_o, busy_o}, 64'b11100);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(req_no && frame_no && irdy_no && !busy_o && !done_o && !retry_o && !disc_o && !rd_valid_o,
        "R1 after reset", {req_no, frame_no, irdy_no, busy_o}, 64'b1110);
    // directed corners
    xfer(4'h7, 64'h0000_0000_0000_1000, 1, 4'hF, 0, -1, 0, 0);
    xfer(4'h6, 64'h0000_0000_0000_2000, 1, 4'h3, 1, -1, 0, 0);
    xfer(4'h6, 64'h0000_0001_0000_0040, 5, 4'hF, 0, 2, 0, 0);
    xfer(4'h7, 64'h0000_0000_0000_3000, 8, 4'hC, 0, -1, 0, 0);
    xfer(4'h6, 64'h0000_0000_0000_4000, 3, 4'hF, 0, 2, 0, 0);
    xfer(4'h7, 64'h0000_0000_0000_5000, 3, 4'h1, 0, 2, 1, 0);
    xfer(4'h6, 64'h0000_0000_FFFF_FFF8, 4, 4'hF, 0, 2, 1, 0);
    xfer(4'h3, 64'h0000_0000_0000_0100, 1, 4'h8, 1, -1, 0, 0);
    // random mix
    for (int k = 0; k < 40; k++) begin
      logic [63:0] a;
      a = {($urandom % 3 == 0) ? 32'($urandom) : 32'h0, 32'($urandom) & 32'hFFFF_FFFC};
      xfer(($urandom % 2) ? 4'h7 : 4'h6, a, 1 + $urandom % 8, 4'($urandom % 15 + 1),
           ($urandom % 5 == 0), -1, 0, 1);
    end
    repeat (2) begin
      @(negedge clk);
      step();
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule